// File: doc/BRIEF.md
# SPI Controller Register Bank with Interrupt Logic

This block is the software-visible face of an SPI controller. It decodes word-addressed writes and reads on a simple strobe bus and holds the settings that the serial engine needs: the clock divider, the transmit and receive mode bits, the DMA handshake enable, the inter-word interval and the two 20-bit transfer lengths. Each length is split into a high register that carries bits 19:16 in its bits 3:0 and a low register that carries bits 15:0.

Some writes produce single-cycle strobes toward the engine instead of stored state: a software transmit or receive request, and a FIFO reset. These registers always read back as zero. The block also collects the engine's two end-of-transfer events. Each event sets a sticky raw status bit. An enable register masks these bits into a masked view. A write-one-to-clear register clears them, and one interrupt line is the OR of the masked bits.

Writes take effect at the clock edge that samples `wr_i`. Reads are combinational while `rd_i` is high, and `rdata_o` is zero otherwise.

Top module: `spi_regbank`

## Requirements
- R1: After reset every output is 0, and every mapped register reads 0 except the busy status, which follows its input.
- R2: The divider register at offset 0x04 stores bits DIV_W-1:0 of the write data, drives `clk_div_o` and reads back those bits, with the upper bits reading 0.
- R3: The mode register at offset 0x0C stores bit 13 as transmit mode and bit 12 as receive mode, drives `tx_mode_o` and `rx_mode_o`, and reads back only these two bits. Writing both bits as 0 leaves both outputs low, which is the idle state.
- R4: Bit 6 of the DMA register at offset 0x10 drives `dma_en_o` and reads back alone.
- R5: The transmit length is held in offset 0x54 (bits 3:0 carry length bits 19:16) and offset 0x58 (bits 15:0 carry length bits 15:0). The receive length uses offsets 0x5C and 0x60 in the same way. A write to one half leaves the other half unchanged.
- R6: A write to the request register at offset 0x64 pulses `sw_tx_req_o` for one cycle when bit 1 is set and pulses `sw_rx_req_o` for one cycle when bit 0 is set. The register reads 0.
- R7: A write of bit 0 as 1 to offset 0x48 pulses `fifo_rst_o` for one cycle. A write of 0 produces no pulse. The register reads 0.
- R8: A high `tx_end_i` sets raw status bit 8 at offset 0x28, and a high `rx_end_i` sets bit 9. Each bit stays set until it is cleared.
- R9: Writing 1 to bit 8 or bit 9 of offset 0x24 clears the matching raw bit, and bits written 0 are untouched. When an event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R10: The enable register at offset 0x20 holds bits 8 and 9. The masked status at offset 0x2C reads raw AND enable at those same bit positions.
- R11: `irq_o` is high exactly when some masked status bit is set.
- R12: Bit 8 of the busy status at offset 0x34 reads the current value of `tx_busy_i`.
- R13: The interval register at offset 0x14 stores bits INTV_W-1:0, drives `interval_o` and reads them back.
- R14: A write to an unmapped or misaligned offset changes no output, and a read of such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Byte offset of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, 0 when no read |
| tx_end_i | input | 1 | Transmit-end event pulse from the engine |
| rx_end_i | input | 1 | Receive-end event pulse from the engine |
| tx_busy_i | input | 1 | Transmit busy level from the engine |
| clk_div_o | output | DIV_W | Clock divider setting |
| tx_mode_o | output | 1 | Transmit mode enable |
| rx_mode_o | output | 1 | Receive mode enable |
| dma_en_o | output | 1 | DMA handshake enable |
| interval_o | output | INTV_W | Inter-word interval setting |
| tx_len_o | output | LEN_W | Transmit length |
| rx_len_o | output | LEN_W | Receive length |
| fifo_rst_o | output | 1 | One-cycle FIFO reset strobe |
| sw_tx_req_o | output | 1 | One-cycle software transmit request |
| sw_rx_req_o | output | 1 | One-cycle software receive request |
| irq_o | output | 1 | Interrupt output |

## Verification
The bench builds the block with its default parameters: a 16-bit divider, an 8-bit interval and 20-bit lengths. With these values every interval code can be swept, a walking one can be run through each divider bit, and a walking one and its complement can be run through every bit of both lengths, so the split at bit 16 is checked on both sides. With only two events, all sixteen combinations of enable and event pattern are covered for the raw view, the masked view and the interrupt line. The same-cycle collision of a clear and an event is also exercised.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int unsigned OFS_DIV  = 'h04;
  localparam int unsigned OFS_MODE = 'h0C;
  localparam int unsigned OFS_DMA  = 'h10;
  localparam int unsigned OFS_INTV = 'h14;
  localparam int unsigned OFS_IEN  = 'h20;
  localparam int unsigned OFS_ICLR = 'h24;
  localparam int unsigned OFS_IRAW = 'h28;
  localparam int unsigned OFS_IMSK = 'h2C;
  localparam int unsigned OFS_BUSY = 'h34;
  localparam int unsigned OFS_FRST = 'h48;
  localparam int unsigned OFS_TXH  = 'h54;
  localparam int unsigned OFS_TXL  = 'h58;
  localparam int unsigned OFS_RXH  = 'h5C;
  localparam int unsigned OFS_RXL  = 'h60;
  localparam int unsigned OFS_REQ  = 'h64;

  localparam int unsigned BIT_RXMODE = 12;
  localparam int unsigned BIT_TXMODE = 13;
  localparam int unsigned BIT_DMA    = 6;
  localparam int unsigned BIT_BUSY   = 8;
  localparam int unsigned BIT_RXREQ  = 0;
  localparam int unsigned BIT_TXREQ  = 1;
  localparam int unsigned BIT_FRST   = 0;

  // event index k lives at status bit EVT_LSB+k
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned EVT_LSB = 8;
  typedef enum logic {EV_TX = 1'b0, EV_RX = 1'b1} evt_e;

  localparam int unsigned LEN_LO_W = 16;
endpackage

// File: rtl/spi_rb_strobe.sv
module spi_rb_strobe #(
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= '0;
    else         pulse_o <= we_i ? bits_i : '0;
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R6 R7: a strobe only follows a write carrying its bit
    a_r6_pulse_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[k] |-> $past(we_i && bits_i[k]));
    a_r7_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !we_i |=> !pulse_o[k]);
  end
endmodule

// File: rtl/spi_rb_len.sv
module spi_rb_len #(
  parameter int unsigned LEN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_hi_i,
  input  logic             we_lo_i,
  input  logic [15:0]      wdata_i,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned LO_W = spi_rb_pkg::LEN_LO_W;
  localparam int unsigned HI_W = LEN_W - LO_W;

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (we_hi_i) hi_q <= wdata_i[HI_W-1:0];
      if (we_lo_i) lo_q <= wdata_i[LO_W-1:0];
    end
  end

  assign len_o = {hi_q, lo_q};

  // R5: halves are independent
  a_r5_hi_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_hi_i |=> $stable(len_o[LEN_W-1:LO_W]));
  a_r5_lo_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_lo_i |=> $stable(len_o[LO_W-1:0]));
endmodule

// File: rtl/spi_rb_irq.sv
module spi_rb_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         en_we_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] wbits_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] msk_o,
  output logic         irq_o
);
  logic [N-1:0] clr;
  assign clr = clr_we_i ? wbits_i : '0;

  for (genvar k = 0; k < N; k++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       raw_o[k] <= 1'b0;
      else if (evt_i[k]) raw_o[k] <= 1'b1;   // set wins over clear
      else if (clr[k])   raw_o[k] <= 1'b0;
    end

    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_o[k] && !clr[k]) |=> raw_o[k]);
    a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> raw_o[k]);
    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[k] && !evt_i[k]) |=> !raw_o[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= wbits_i;
  end

  assign msk_o = raw_o & en_o;
  assign irq_o = |msk_o;

  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |-> !irq_o);
  a_r10_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_o & ~raw_o) == '0);
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_rb_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned INTV_W = 8,
  parameter int unsigned LEN_W  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_end_i,
  input  logic              rx_end_i,
  input  logic              tx_busy_i,
  output logic [DIV_W-1:0]  clk_div_o,
  output logic              tx_mode_o,
  output logic              rx_mode_o,
  output logic              dma_en_o,
  output logic [INTV_W-1:0] interval_o,
  output logic [LEN_W-1:0]  tx_len_o,
  output logic [LEN_W-1:0]  rx_len_o,
  output logic              fifo_rst_o,
  output logic              sw_tx_req_o,
  output logic              sw_rx_req_o,
  output logic              irq_o
);
  localparam int unsigned LO_W = LEN_LO_W;
  localparam int unsigned HI_W = LEN_W - LO_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic unused_wdata;
  assign unused_wdata = ^wdata_i[DATA_W-1:16];

  logic we_div, we_mode, we_dma, we_intv, we_ien, we_iclr;
  logic we_frst, we_req, we_txh, we_txl, we_rxh, we_rxl;
  assign we_div  = wr_i && hit(addr_i, OFS_DIV);
  assign we_mode = wr_i && hit(addr_i, OFS_MODE);
  assign we_dma  = wr_i && hit(addr_i, OFS_DMA);
  assign we_intv = wr_i && hit(addr_i, OFS_INTV);
  assign we_ien  = wr_i && hit(addr_i, OFS_IEN);
  assign we_iclr = wr_i && hit(addr_i, OFS_ICLR);
  assign we_frst = wr_i && hit(addr_i, OFS_FRST);
  assign we_req  = wr_i && hit(addr_i, OFS_REQ);
  assign we_txh  = wr_i && hit(addr_i, OFS_TXH);
  assign we_txl  = wr_i && hit(addr_i, OFS_TXL);
  assign we_rxh  = wr_i && hit(addr_i, OFS_RXH);
  assign we_rxl  = wr_i && hit(addr_i, OFS_RXL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_div_o  <= '0;
      tx_mode_o  <= 1'b0;
      rx_mode_o  <= 1'b0;
      dma_en_o   <= 1'b0;
      interval_o <= '0;
    end else begin
      if (we_div)  clk_div_o <= wdata_i[DIV_W-1:0];
      if (we_mode) begin
        tx_mode_o <= wdata_i[BIT_TXMODE];
        rx_mode_o <= wdata_i[BIT_RXMODE];
      end
      if (we_dma)  dma_en_o   <= wdata_i[BIT_DMA];
      if (we_intv) interval_o <= wdata_i[INTV_W-1:0];
    end
  end

  spi_rb_len #(.LEN_W(LEN_W)) u_tx_len (
    .clk_i, .rst_ni, .we_hi_i(we_txh), .we_lo_i(we_txl),
    .wdata_i(wdata_i[15:0]), .len_o(tx_len_o));

  spi_rb_len #(.LEN_W(LEN_W)) u_rx_len (
    .clk_i, .rst_ni, .we_hi_i(we_rxh), .we_lo_i(we_rxl),
    .wdata_i(wdata_i[15:0]), .len_o(rx_len_o));

  logic [1:0] req_pulse;
  spi_rb_strobe #(.N(2)) u_req (
    .clk_i, .rst_ni, .we_i(we_req),
    .bits_i({wdata_i[BIT_TXREQ], wdata_i[BIT_RXREQ]}),
    .pulse_o(req_pulse));
  assign sw_tx_req_o = req_pulse[1];
  assign sw_rx_req_o = req_pulse[0];

  spi_rb_strobe #(.N(1)) u_frst (
    .clk_i, .rst_ni, .we_i(we_frst),
    .bits_i(wdata_i[BIT_FRST]), .pulse_o(fifo_rst_o));

  logic [NUM_EVT-1:0] evt, raw, en, msk;
  assign evt[EV_TX] = tx_end_i;
  assign evt[EV_RX] = rx_end_i;

  spi_rb_irq #(.N(NUM_EVT)) u_irq (
    .clk_i, .rst_ni, .evt_i(evt), .en_we_i(we_ien), .clr_we_i(we_iclr),
    .wbits_i(wdata_i[EVT_LSB +: NUM_EVT]),
    .raw_o(raw), .en_o(en), .msk_o(msk), .irq_o(irq_o));

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit(addr_i, OFS_DIV))  rdata_o = DATA_W'(clk_div_o);
      if (hit(addr_i, OFS_MODE)) begin
        rdata_o[BIT_TXMODE] = tx_mode_o;
        rdata_o[BIT_RXMODE] = rx_mode_o;
      end
      if (hit(addr_i, OFS_DMA))  rdata_o[BIT_DMA] = dma_en_o;
      if (hit(addr_i, OFS_INTV)) rdata_o = DATA_W'(interval_o);
      if (hit(addr_i, OFS_IEN))  rdata_o[EVT_LSB +: NUM_EVT] = en;
      if (hit(addr_i, OFS_IRAW)) rdata_o[EVT_LSB +: NUM_EVT] = raw;
      if (hit(addr_i, OFS_IMSK)) rdata_o[EVT_LSB +: NUM_EVT] = msk;
      if (hit(addr_i, OFS_BUSY)) rdata_o[BIT_BUSY] = tx_busy_i;
      if (hit(addr_i, OFS_TXH))  rdata_o = DATA_W'(tx_len_o[LEN_W-1:LO_W]);
      if (hit(addr_i, OFS_TXL))  rdata_o = DATA_W'(tx_len_o[LO_W-1:0]);
      if (hit(addr_i, OFS_RXH))  rdata_o = DATA_W'(rx_len_o[LEN_W-1:LO_W]);
      if (hit(addr_i, OFS_RXL))  rdata_o = DATA_W'(rx_len_o[LO_W-1:0]);
    end
  end

  // R3: mode bits only move on a mode write
  a_r3_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_mode |=> $stable({tx_mode_o, rx_mode_o}));
  // R2: divider only moves on a divider write
  a_r2_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_div |=> $stable(clk_div_o));
  // R14: no read strobe, no data
  a_r14_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> (rdata_o == '0));
  // R6: requests are single-cycle unless rewritten
  a_r6_req_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_tx_req_o && !we_req) |=> !sw_tx_req_o);
endmodule

// File: tb/spi_regbank_test.sv
module spi_regbank_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;
  logic tx_end_i = 1'b0, rx_end_i = 1'b0, tx_busy_i = 1'b0;
  logic [15:0] clk_div_o;
  logic tx_mode_o, rx_mode_o, dma_en_o;
  logic [7:0] interval_o;
  logic [19:0] tx_len_o, rx_len_o;
  logic fifo_rst_o, sw_tx_req_o, sw_rx_req_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_regbank uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic evt(input logic t, input logic r);
    @(negedge clk_i);
    tx_end_i = t; rx_end_i = r;
    @(negedge clk_i);
    tx_end_i = 1'b0; rx_end_i = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {clk_div_o[7:0], interval_o, tx_len_o[3:0], rx_len_o[3:0],
            tx_mode_o, rx_mode_o, dma_en_o, fifo_rst_o, sw_tx_req_o, sw_rx_req_o, irq_o, 1'b0};
  endfunction

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [31:0] snap;
    logic [7:0] ofs [15];
    ofs = '{8'h04, 8'h0C, 8'h10, 8'h14, 8'h20, 8'h24, 8'h28, 8'h2C,
            8'h34, 8'h48, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 outputs", outs(), 32'h0);
    chk("R1 txlen", {12'h0, tx_len_o}, 32'h0);
    chk("R1 rxlen", {12'h0, rx_len_o}, 32'h0);
    for (int i = 0; i < 15; i++) begin
      rd(ofs[i], v);
      chk("R1 readback", v, 32'h0);
    end

    // R2 divider walking one with upper garbage
    for (int i = 0; i < 16; i++) begin
      wr(8'h04, 32'hFFFF_0000 | (32'h1 << i));
      chk("R2 clk_div_o", {16'h0, clk_div_o}, 32'h1 << i);
      rd(8'h04, v);
      chk("R2 readback", v, 32'h1 << i);
    end

    // R13 interval full sweep
    for (int i = 0; i < 256; i++) begin
      wr(8'h14, 32'hFFFF_FF00 | i);
      chk("R13 interval_o", {24'h0, interval_o}, i);
      rd(8'h14, v);
      chk("R13 readback", v, i);
    end

    // R3 mode combos, ending in idle
    for (int i = 3; i >= 0; i--) begin
      wr(8'h0C, 32'hFFFF_CFFF | (i << 12));
      chk("R3 tx_mode_o", {31'h0, tx_mode_o}, (i >> 1) & 1);
      chk("R3 rx_mode_o", {31'h0, rx_mode_o}, i & 1);
      rd(8'h0C, v);
      chk("R3 readback", v, i << 12);
    end

    // R4 DMA enable
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R4 dma_en_o set", {31'h0, dma_en_o}, 1);
    rd(8'h10, v);
    chk("R4 readback", v, 32'h40);
    wr(8'h10, 32'hFFFF_FFBF);
    chk("R4 dma_en_o clear", {31'h0, dma_en_o}, 0);

    // R5 lengths: walking one on tx, its complement on rx
    for (int i = 0; i < 20; i++) begin
      logic [19:0] tv, rv;
      tv = 20'h1 << i;
      rv = ~tv;
      wr(8'h54, 32'hFFFF_FFF0 | tv[19:16]);
      wr(8'h58, 32'hFFFF_0000 | tv[15:0]);
      wr(8'h5C, 32'hFFFF_FFF0 | rv[19:16]);
      wr(8'h60, 32'hFFFF_0000 | rv[15:0]);
      chk("R5 tx_len_o", {12'h0, tx_len_o}, {12'h0, tv});
      chk("R5 rx_len_o", {12'h0, rx_len_o}, {12'h0, rv});
      rd(8'h54, v); chk("R5 tx hi read", v, tv[19:16]);
      rd(8'h60, v); chk("R5 rx lo read", v, rv[15:0]);
    end
    wr(8'h54, 32'h5);
    chk("R5 hi write keeps lo", {12'h0, tx_len_o}, {12'h0, 4'h5, 16'h0000});
    wr(8'h60, 32'h1234);
    chk("R5 lo write keeps hi", {12'h0, rx_len_o}, {12'h0, 4'h7, 16'h1234});

    // R12 busy status
    tx_busy_i = 1'b1; rd(8'h34, v); chk("R12 busy high", v, 32'h100);
    tx_busy_i = 1'b0; rd(8'h34, v); chk("R12 busy low", v, 32'h0);

    // R6 software requests
    for (int i = 0; i < 4; i++) begin
      wr(8'h64, 32'hFFFF_FFFC | i);
      chk("R6 sw_tx_req_o pulse", {31'h0, sw_tx_req_o}, (i >> 1) & 1);
      chk("R6 sw_rx_req_o pulse", {31'h0, sw_rx_req_o}, i & 1);
      rd(8'h64, v); chk("R6 readback", v, 0);
      @(negedge clk_i);
      chk("R6 pulse ends", {30'h0, sw_tx_req_o, sw_rx_req_o}, 0);
    end

    // R7 FIFO reset
    wr(8'h48, 32'h1);
    chk("R7 fifo_rst_o pulse", {31'h0, fifo_rst_o}, 1);
    rd(8'h48, v); chk("R7 readback", v, 0);
    @(negedge clk_i);
    chk("R7 pulse ends", {31'h0, fifo_rst_o}, 0);
    wr(8'h48, 32'h0);
    chk("R7 zero write no pulse", {31'h0, fifo_rst_o}, 0);

    // R8 R9 R10 R11 sweep of enable x event pattern
    for (int en = 0; en < 4; en++) begin
      for (int ev = 0; ev < 4; ev++) begin
        wr(8'h24, 32'h300);
        wr(8'h20, 32'hFFFF_FCFF | (en << 8));
        chk("R9 cleared before", {31'h0, irq_o}, 0);
        evt(ev[0], ev[1]);
        rd(8'h28, v); chk("R8 raw", v, ev << 8);
        rd(8'h2C, v); chk("R10 masked", v, (ev & en) << 8);
        rd(8'h20, v); chk("R10 enable readback", v, en << 8);
        chk("R11 irq_o", {31'h0, irq_o}, ((ev & en) != 0) ? 1 : 0);
        @(negedge clk_i);
        rd(8'h28, v); chk("R8 sticky", v, ev << 8);
        wr(8'h24, 32'h100);
        rd(8'h28, v); chk("R9 partial clear", v, (ev & 2) << 8);
      end
    end

    // R9 clear and event collide: bit stays set
    wr(8'h24, 32'h300);
    @(negedge clk_i);
    addr_i = 8'h24; wdata_i = 32'h300; wr_i = 1'b1; tx_end_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; tx_end_i = 1'b0;
    rd(8'h28, v); chk("R9 set wins", v, 32'h100);
    wr(8'h24, 32'h200);
    rd(8'h28, v); chk("R9 other bit untouched", v, 32'h100);

    // R14 unmapped and misaligned writes
    @(negedge clk_i);
    snap = outs();
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    chk("R14 outputs unchanged", outs(), snap);
    rd(8'h70, v); chk("R14 unmapped read", v, 0);
    rd(8'h05, v); chk("R14 misaligned read", v, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule